// File: doc/BRIEF.md
# Instruction Decode Stage with Register-Indirect Jump and Immediate Shift

This block is the decode stage of a small five-stage integer pipeline. Each cycle it looks at the instruction word held in the fetch/decode pipeline register and drives the two read addresses of the register file. From the two values that come back it builds the operands for the execute stage and registers them into the decode/execute pipeline register, along with the ALU operation, the destination register and a write enable.

Four register-format instructions are recognised: add, subtract, shift-left-logical and jump-register. For a shift-left-logical, the value to shift is the register selected by the rt field, and the shift distance is the 5-bit shamt field, zero-extended. A jump-register is resolved in this stage. In the same cycle the block raises a redirect strobe whose target is the full value of register rs, and it asks for the fetch/decode register to be flushed. Every other word leaves the stage as a no-op with writes disabled. This includes the all-zero word, unknown function codes, and a jump-register whose spare fields are not zero.

Top module: `id_decode_stage`

## Requirements
- R1: The read address for port A is instruction bits 25:21 (rs). The read address for port B is bits 20:16 (rt). Both are combinational from the instruction.
- R2: An add (opcode bits 31:26 = 0, funct bits 5:0 = 6'b100000) loads the following on the next rising clock: operand A = rs value, operand B = rt value, ALU op 2'b00, destination = bits 15:11 (rd), write enable 1.
- R3: A subtract (opcode 0, funct 6'b100010) loads the same as R2, but with ALU op 2'b01.
- R4: A shift-left-logical (opcode 0, funct 6'b000000, word not all zero) loads the following: operand A = rt value, operand B = bits 10:6 zero-extended, ALU op 2'b10, destination = rd.
- R5: A jump-register (opcode 0, funct 6'b001000, bits 20:6 all zero) raises the redirect strobe and the flush request in the same cycle, with the redirect target equal to the rs value.
- R6: A jump-register loads a no-op into the decode/execute register. A no-op is operands 0, ALU op 2'b00, destination 0, write enable 0.
- R7: The instruction presented in the cycle after an accepted jump-register is squashed. It loads a no-op and raises no redirect, so the strobe lasts exactly one cycle.
- R8: The write enable is never 1 when the destination is register 0. The all-zero word loads a no-op.
- R9: The following decode to a no-op with no redirect and no squash of the next instruction: a non-zero opcode, an unlisted funct, or a jump-register with any of bits 20:6 set.
- R10: While reset is low, the decode/execute register holds the no-op.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| ifid_instr | input | 32 | Instruction from the fetch/decode register |
| rf_raddr_a | output | 5 | Register-file read address, port A (rs) |
| rf_raddr_b | output | 5 | Register-file read address, port B (rt) |
| rf_rdata_a | input | XLEN | Register-file read data, port A |
| rf_rdata_b | input | XLEN | Register-file read data, port B |
| idex_opa | output | XLEN | Registered ALU operand A |
| idex_opb | output | XLEN | Registered ALU operand B |
| idex_aluop | output | 2 | Registered ALU operation |
| idex_rd | output | 5 | Registered destination register |
| idex_we | output | 1 | Registered register-write enable |
| redir_taken | output | 1 | Next-PC redirect strobe |
| redir_target | output | XLEN | Redirect target address |
| ifid_flush | output | 1 | Request to clear the fetch/decode register on the next clock |

## Verification
The bench goes after shift-left-logical operand steering. A design that left the operand selects at their defaults would send the rs value and the rt value where the rt value and the shamt are wanted. It also issues a jump-register followed at once by an add. A design without the squash would either write back the add or repeat the redirect. Jump-register words with a non-zero spare field, writes to register 0 and the all-zero word are all included. Mistaking any of these for a valid instruction shows up as a stray write enable or a stray redirect.

// File: rtl/id_decode_pkg.sv
package id_decode_pkg;

   localparam int INSTR_W = 32;
   localparam int REG_AW  = 5;
   localparam int SHAMT_W = 5;
   localparam int FUNCT_W = 6;

   localparam logic [FUNCT_W-1:0] FN_SLL = 6'b000000;
   localparam logic [FUNCT_W-1:0] FN_JR  = 6'b001000;
   localparam logic [FUNCT_W-1:0] FN_ADD = 6'b100000;
   localparam logic [FUNCT_W-1:0] FN_SUB = 6'b100010;

   typedef enum logic [1:0] {
      ALU_ADD = 2'b00,
      ALU_SUB = 2'b01,
      ALU_SLL = 2'b10
   } alu_op_e;

   typedef struct packed {
      logic    valid;        // produces an ID/EX result (not a no-op)
      logic    wr_en;        // register write requested
      logic    is_jr;        // accepted register-indirect jump
      logic    sel_a_rt;     // operand A from rt instead of rs
      logic    sel_b_shamt;  // operand B from shamt instead of rt
      alu_op_e op;
   } dec_ctl_t;

endpackage

// File: rtl/id_field_decode.sv
module id_field_decode
   import id_decode_pkg::*;
(
   input  logic [INSTR_W-1:0] instr,
   input  logic               squash,
   output dec_ctl_t           ctl
);

   logic [5:0]         opc;
   logic [FUNCT_W-1:0] fn;
   logic [REG_AW-1:0]  dst;
   logic               spare_zero;
   logic               word_zero;

   assign opc        = instr[31:26];
   assign fn         = instr[FUNCT_W-1:0];
   assign dst        = instr[15:11];
   assign spare_zero = (instr[20:6] == '0);
   assign word_zero  = (instr == '0);

   always_comb begin
      ctl = '{valid: 1'b0, wr_en: 1'b0, is_jr: 1'b0,
              sel_a_rt: 1'b0, sel_b_shamt: 1'b0, op: ALU_ADD};
      if (!squash && opc == 6'd0 && !word_zero) begin
         unique case (fn)
            FN_ADD: begin
               ctl.valid = 1'b1;
               ctl.op    = ALU_ADD;
            end
            FN_SUB: begin
               ctl.valid = 1'b1;
               ctl.op    = ALU_SUB;
            end
            FN_SLL: begin
               ctl.valid       = 1'b1;
               ctl.op          = ALU_SLL;
               ctl.sel_a_rt    = 1'b1;
               ctl.sel_b_shamt = 1'b1;
            end
            FN_JR: begin
               ctl.is_jr = spare_zero;
            end
            default: ;
         endcase
         ctl.wr_en = ctl.valid && (dst != '0);
      end
   end

endmodule

// File: rtl/id_operand_mux.sv
module id_operand_mux #(
   parameter int XLEN    = 32,
   parameter int SHAMT_W = 5
) (
   input  logic               sel_a_rt,
   input  logic               sel_b_shamt,
   input  logic [XLEN-1:0]    rs_val,
   input  logic [XLEN-1:0]    rt_val,
   input  logic [SHAMT_W-1:0] shamt,
   output logic [XLEN-1:0]    opa,
   output logic [XLEN-1:0]    opb
);

   localparam int PAD_W = XLEN - SHAMT_W;

   logic [XLEN-1:0] shamt_ext;

   generate
      if (PAD_W > 0) begin : g_pad
         assign shamt_ext = {{PAD_W{1'b0}}, shamt};
      end else begin : g_nopad
         assign shamt_ext = shamt[XLEN-1:0];
      end
   endgenerate

   assign opa = sel_a_rt    ? rt_val    : rs_val;
   assign opb = sel_b_shamt ? shamt_ext : rt_val;

endmodule

// File: rtl/id_redirect.sv
module id_redirect #(
   parameter int XLEN         = 32,
   parameter bit SHADOW_SQUASH = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            is_jr,
   input  logic [XLEN-1:0] rs_val,
   output logic            taken,
   output logic [XLEN-1:0] target,
   output logic            flush,
   output logic            squash
);

   assign taken  = is_jr;
   assign target = rs_val;
   assign flush  = is_jr;

   generate
      if (SHADOW_SQUASH) begin : g_shadow
         logic flush_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) flush_q <= 1'b0;
            else        flush_q <= is_jr;
         end
         assign squash = flush_q;
      end else begin : g_noshadow
         assign squash = 1'b0;
      end
   endgenerate

endmodule

// File: rtl/id_decode_stage.sv
module id_decode_stage
   import id_decode_pkg::*;
#(
   parameter int XLEN          = 32,
   parameter bit SHADOW_SQUASH = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [INSTR_W-1:0] ifid_instr,
   output logic [REG_AW-1:0]  rf_raddr_a,
   output logic [REG_AW-1:0]  rf_raddr_b,
   input  logic [XLEN-1:0]    rf_rdata_a,
   input  logic [XLEN-1:0]    rf_rdata_b,
   output logic [XLEN-1:0]    idex_opa,
   output logic [XLEN-1:0]    idex_opb,
   output logic [1:0]         idex_aluop,
   output logic [REG_AW-1:0]  idex_rd,
   output logic               idex_we,
   output logic               redir_taken,
   output logic [XLEN-1:0]    redir_target,
   output logic               ifid_flush
);

   initial begin
      assert (XLEN >= 8) else $fatal(1, "id_decode_stage: XLEN must be at least 8");
   end

   dec_ctl_t        ctl;
   logic            squash;
   logic [XLEN-1:0] opa_d;
   logic [XLEN-1:0] opb_d;

   assign rf_raddr_a = ifid_instr[25:21];
   assign rf_raddr_b = ifid_instr[20:16];

   id_field_decode u_dec (
      .instr  (ifid_instr),
      .squash (squash),
      .ctl    (ctl)
   );

   id_operand_mux #(.XLEN(XLEN), .SHAMT_W(SHAMT_W)) u_opmux (
      .sel_a_rt    (ctl.sel_a_rt),
      .sel_b_shamt (ctl.sel_b_shamt),
      .rs_val      (rf_rdata_a),
      .rt_val      (rf_rdata_b),
      .shamt       (ifid_instr[10:6]),
      .opa         (opa_d),
      .opb         (opb_d)
   );

   id_redirect #(.XLEN(XLEN), .SHADOW_SQUASH(SHADOW_SQUASH)) u_redir (
      .clk    (clk),
      .rst_n  (rst_n),
      .is_jr  (ctl.is_jr),
      .rs_val (rf_rdata_a),
      .taken  (redir_taken),
      .target (redir_target),
      .flush  (ifid_flush),
      .squash (squash)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idex_opa   <= '0;
         idex_opb   <= '0;
         idex_aluop <= ALU_ADD;
         idex_rd    <= '0;
         idex_we    <= 1'b0;
      end else if (ctl.valid) begin
         idex_opa   <= opa_d;
         idex_opb   <= opb_d;
         idex_aluop <= ctl.op;
         idex_rd    <= ifid_instr[15:11];
         idex_we    <= ctl.wr_en;
      end else begin
         idex_opa   <= '0;
         idex_opb   <= '0;
         idex_aluop <= ALU_ADD;
         idex_rd    <= '0;
         idex_we    <= 1'b0;
      end
   end

endmodule

// File: rtl/id_decode_checker.sv
module id_decode_checker #(
   parameter int XLEN = 32
) (
   input logic            clk,
   input logic            rst_n,
   input logic [31:0]     ifid_instr,
   input logic [XLEN-1:0] rf_rdata_a,
   input logic [XLEN-1:0] idex_opb,
   input logic [1:0]      idex_aluop,
   input logic [4:0]      idex_rd,
   input logic            idex_we,
   input logic            redir_taken,
   input logic [XLEN-1:0] redir_target,
   input logic            ifid_flush
);

   logic taken_q;
   logic sll_now;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) taken_q <= 1'b0;
      else        taken_q <= redir_taken;
   end

   assign sll_now = (ifid_instr[31:26] == 6'd0) && (ifid_instr[5:0] == 6'd0)
                    && (ifid_instr != 32'd0);

   // R8: no write to register 0
   assert_no_write_r0_R8: assert property (@(posedge clk) disable iff (!rst_n)
      idex_we |-> (idex_rd != 5'd0));

   // R8: all-zero word leaves as a no-op
   assert_zero_word_noop_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (ifid_instr == 32'd0) |=> (!idex_we && idex_aluop == 2'b00));

   // R5: redirect carries the rs value and a flush request
   assert_redirect_target_R5: assert property (@(posedge clk) disable iff (!rst_n)
      redir_taken |-> (ifid_flush && redir_target == rf_rdata_a));

   // R6: jump loads no write
   assert_jr_no_write_R6: assert property (@(posedge clk) disable iff (!rst_n)
      redir_taken |=> !idex_we);

   // R7: strobe lasts one cycle
   assert_single_redirect_R7: assert property (@(posedge clk) disable iff (!rst_n)
      redir_taken |=> !redir_taken);

   // R2: only the three defined ALU codes appear
   assert_aluop_legal_R2: assert property (@(posedge clk) disable iff (!rst_n)
      idex_aluop != 2'b11);

   // R4: shift uses the zero-extended shamt as operand B
   assert_sll_shamt_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (sll_now && !taken_q) |=>
         (idex_opb == {{(XLEN-5){1'b0}}, $past(ifid_instr[10:6])} && idex_aluop == 2'b10));

endmodule

bind id_decode_stage id_decode_checker #(.XLEN(XLEN)) u_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .ifid_instr   (ifid_instr),
   .rf_rdata_a   (rf_rdata_a),
   .idex_opb     (idex_opb),
   .idex_aluop   (idex_aluop),
   .idex_rd      (idex_rd),
   .idex_we      (idex_we),
   .redir_taken  (redir_taken),
   .redir_target (redir_target),
   .ifid_flush   (ifid_flush)
);

// File: tb/test_id_decode_stage.sv
`timescale 1ns/1ps
module test_id_decode_stage;

   localparam int XLEN = 32;

   logic            clk = 1'b0;
   logic            rst_n = 1'b0;
   logic [31:0]     instr = 32'd0;
   logic [4:0]      raddr_a, raddr_b;
   logic [XLEN-1:0] rdata_a, rdata_b;
   logic [XLEN-1:0] opa, opb;
   logic [1:0]      aluop;
   logic [4:0]      rd;
   logic            we, taken, flush;
   logic [XLEN-1:0] target;

   int n_cmp = 0;
   int n_bad = 0;

   always #5 clk = ~clk;

   function automatic logic [XLEN-1:0] regval(input logic [4:0] idx);
      return (idx == 5'd0) ? '0 : (32'hA000_0000 | (32'(idx) << 8) | 32'(idx));
   endfunction

   assign rdata_a = regval(raddr_a);
   assign rdata_b = regval(raddr_b);

   id_decode_stage i_id_decode_stage (
      .clk(clk), .rst_n(rst_n), .ifid_instr(instr),
      .rf_raddr_a(raddr_a), .rf_raddr_b(raddr_b),
      .rf_rdata_a(rdata_a), .rf_rdata_b(rdata_b),
      .idex_opa(opa), .idex_opb(opb), .idex_aluop(aluop),
      .idex_rd(rd), .idex_we(we),
      .redir_taken(taken), .redir_target(target), .ifid_flush(flush)
   );

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   // drive at negedge, settle, leave caller to check comb outputs
   task automatic present(input logic [31:0] w);
      @(negedge clk);
      instr = w;
      #1;
   endtask

   task automatic after_edge();
      @(posedge clk);
      #1;
   endtask

   task automatic chk_idex(input string tag, input logic [31:0] ea, input logic [31:0] eb,
                           input logic [1:0] eop, input logic [4:0] erd, input logic ewe);
      chk({tag, " opa"}, opa, ea);
      chk({tag, " opb"}, opb, eb);
      chk({tag, " aluop"}, 32'(aluop), 32'(eop));
      chk({tag, " rd"}, 32'(rd), 32'(erd));
      chk({tag, " we"}, 32'(we), 32'(ewe));
   endtask

   task automatic t_reset();
      chk_idex("R10 reset", 0, 0, 2'b00, 5'd0, 1'b0);
      chk("R10 no redirect in reset", 32'(taken), 0);
   endtask

   task automatic t_add();
      present(32'h0022_1820); // add $3,$1,$2
      chk("R1 raddr_a", 32'(raddr_a), 1);
      chk("R1 raddr_b", 32'(raddr_b), 2);
      chk("R9 add no redirect", 32'(taken), 0);
      after_edge();
      chk_idex("R2 add", regval(1), regval(2), 2'b00, 5'd3, 1'b1);
   endtask

   task automatic t_sub();
      present(32'h00C7_2822); // sub $5,$6,$7
      after_edge();
      chk_idex("R3 sub", regval(6), regval(7), 2'b01, 5'd5, 1'b1);
   endtask

   task automatic t_sll();
      present(32'h0009_4140); // sll $8,$9,5
      chk("R1 sll raddr_b", 32'(raddr_b), 9);
      after_edge();
      chk_idex("R4 sll", regval(9), 32'd5, 2'b10, 5'd8, 1'b1);
      present(32'h000A_67C0); // sll $12,$10,31
      after_edge();
      chk_idex("R4 sll max shamt", regval(10), 32'd31, 2'b10, 5'd12, 1'b1);
   endtask

   task automatic t_jr_squash();
      present(32'h0080_0008); // jr $4
      chk("R5 taken", 32'(taken), 1);
      chk("R5 flush", 32'(flush), 1);
      chk("R5 target", target, regval(4));
      after_edge();
      chk_idex("R6 jr no-op", 0, 0, 2'b00, 5'd0, 1'b0);
      present(32'h0022_1820); // shadow add, must be squashed
      chk("R7 shadow no redirect", 32'(taken), 0);
      after_edge();
      chk_idex("R7 shadow squashed", 0, 0, 2'b00, 5'd0, 1'b0);
      present(32'h0022_1820); // same add again, now live
      after_edge();
      chk_idex("R7 after shadow", regval(1), regval(2), 2'b00, 5'd3, 1'b1);
   endtask

   task automatic t_rd_zero();
      present(32'h0022_0020); // add $0,$1,$2
      after_edge();
      chk("R8 rd0 we", 32'(we), 0);
      present(32'h0000_0000);
      after_edge();
      chk_idex("R8 zero word", 0, 0, 2'b00, 5'd0, 1'b0);
   endtask

   task automatic t_illegal();
      present(32'h0022_1825); // unlisted funct
      after_edge();
      chk_idex("R9 bad funct", 0, 0, 2'b00, 5'd0, 1'b0);
      present(32'h2022_1820); // non-zero opcode
      after_edge();
      chk_idex("R9 bad opcode", 0, 0, 2'b00, 5'd0, 1'b0);
      present(32'h0080_0808); // jr with rd field set
      chk("R9 bad jr no redirect", 32'(taken), 0);
      chk("R9 bad jr no flush", 32'(flush), 0);
      after_edge();
      present(32'h00C7_2822); // must not be squashed
      after_edge();
      chk_idex("R9 no squash after bad jr", regval(6), regval(7), 2'b01, 5'd5, 1'b1);
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin : main
      repeat (3) @(posedge clk);
      #1;
      t_reset();
      @(negedge clk);
      rst_n = 1'b1;
      t_add();
      t_sub();
      t_sll();
      t_jr_squash();
      t_rd_zero();
      t_illegal();
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule